// File: doc/BRIEF.md
# Framebuffer Line DMA Fetcher

This block pulls one frame of pixel data out of memory and lands it, beat by beat, in a local FIFO that a display pipeline drains. Software-facing setup arrives as plain configuration inputs. These are a base address, a line size in bytes, a line count, and a signed pitch that moves the start address from one line to the next. Because the pitch can be negative, a frame stored bottom-up is read in display order.

The fetcher issues burst read requests on a simple 64-bit request/return interface. Responses come back in request order, and each response burst ends with a last marker. Two limits gate every request. The first is the number of bursts still in flight. The second is the free room in the FIFO, which must hold the new burst as well as every beat still owed by memory. A burst never crosses the end of a line.

A frame-start pulse begins a frame. An abort pulse stops it, and any data still on its way back is thrown away. An underrun pulse from the display side halts all new requests until the next frame start. The block reports two events as single-cycle pulses: a finished frame, and a beat that came back with an error.

Top module: `fb_line_fetch`

## Requirements
- R1: While reset is held and until the first frame start, `rq_valid`, `dma_end` and `bus_err` are 0 and `fifo_empty` is 1.
- R2: The first request of a frame goes to `cfg_base`. Within a line, requests cover consecutive 8-byte beats. Each line begins at the previous line's start plus `cfg_pitch`, taken as a signed two's-complement value.
- R3: Each request asks for min(B, beats left in the line) beats. B is `cfg_burst` clamped to 16, and a `cfg_burst` of 0 counts as 1. The line length in beats is `cfg_line_bytes` divided by 8, with the low 3 bits ignored.
- R4: A request is accepted only while fewer than M bursts are outstanding. M is `cfg_max_out`, and 0 counts as 1. A burst stops being outstanding once its beat marked `rd_last` has been taken.
- R5: A request is offered only if FIFO occupancy plus beats still owed plus the new burst fit within the FIFO depth.
- R6: Every beat returned for the current frame is stored whole, in return order, and `fifo_data` always shows the oldest stored beat.
- R7: `dma_end` pulses for exactly one cycle once per frame, after all lines have been requested and all of their beats have returned. A frame with zero lines pulses it without issuing any request.
- R8: `bus_err` pulses for one cycle for each current-frame beat returned with `rd_err` set.
- R9: After an `underrun` pulse, no request is accepted until the next frame start, and that frame produces no `dma_end`.
- R10: `abort` or `frame_start` empties the FIFO. Every beat belonging to a request accepted before that pulse is then dropped.
- R11: An offered request that is not accepted stays offered with the same address and size until it is taken, unless a start, abort or underrun pulse arrives.
- R12: A frame start after an underrun fetches its frame normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Begin fetching a frame (pulse) |
| abort | input | 1 | Stop the current frame and discard in-flight data (pulse) |
| underrun | input | 1 | Display ran dry; stop requests for this frame (pulse) |
| cfg_base | input | 32 | Byte address of the first line |
| cfg_line_bytes | input | LEN_W | Bytes per line, a multiple of 8 |
| cfg_lines | input | 12 | Number of lines in the frame |
| cfg_pitch | input | 32 | Signed line-to-line address step |
| cfg_burst | input | 5 | Beats per burst |
| cfg_max_out | input | 4 | Bursts allowed in flight |
| rq_valid | output | 1 | Read request offered |
| rq_ready | input | 1 | Read request taken |
| rq_addr | output | 32 | Byte address of the burst |
| rq_beats | output | 5 | Beats in the burst, 1 to 16 |
| rd_valid | input | 1 | Return beat present |
| rd_data | input | 64 | Return beat |
| rd_last | input | 1 | Final beat of a burst |
| rd_err | input | 1 | Beat carries an error response |
| fifo_pop | input | 1 | Remove the oldest FIFO beat |
| fifo_data | output | 64 | Oldest FIFO beat |
| fifo_empty | output | 1 | FIFO holds nothing |
| dma_end | output | 1 | Frame fetched (pulse) |
| bus_err | output | 1 | Error beat seen (pulse) |

## Verification
The bench builds the fetcher with a 32-entry FIFO and a 16-bit line-size input. At that depth, two full 16-beat bursts exhaust the room, so the admission rule shows up as soon as the reader stops draining. Random ready, response gaps and pop gaps keep requests waiting and data in flight. This lets held requests, stale beats after an abort, and the outstanding-burst ceiling occur at small frame sizes, with pitches of both signs.

// File: rtl/fb_fetch_pkg.sv
package fb_fetch_pkg;
  localparam int ADDR_W    = 32;
  localparam int BEAT_W    = 64;
  localparam int BEAT_SH   = 3;   // log2 of bytes per beat
  localparam int MAX_BEATS = 16;
  localparam int BURST_W   = 5;
  localparam int OUT_W     = 4;
  localparam int LINES_W   = 12;
  localparam int CNT_W     = OUT_W + 1;
endpackage

// File: rtl/fb_pixel_fifo.sv
module fb_pixel_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] level
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          do_pop;

  assign empty  = (cnt_q == '0);
  assign full   = (cnt_q == CW'(DEPTH));
  assign level  = cnt_q;
  assign dout   = mem[rd_q];
  assign do_pop = pop && !empty;

  always_comb begin
    wr_n  = wr_q;
    rd_n  = rd_q;
    cnt_n = cnt_q;
    if (flush) begin
      wr_n  = '0;
      rd_n  = '0;
      cnt_n = '0;
    end else begin
      if (push)   wr_n = wr_q + AW'(1);
      if (do_pop) rd_n = rd_q + AW'(1);
      cnt_n = cnt_q + CW'(push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wr_q] <= din;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full); // R5
endmodule

// File: rtl/fb_burst_tracker.sv
module fb_burst_tracker import fb_fetch_pkg::*; #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [BURST_W-1:0] issue_beats,
  input  logic               rd_valid,
  input  logic               rd_last,
  input  logic               restart,
  output logic [CNT_W-1:0]   out_cnt,
  output logic [CW-1:0]      beats_out,
  output logic               stale,
  output logic               live_idle
);
  logic [CNT_W-1:0] out_q, out_n, disc_q, disc_n;
  logic [CW-1:0]    bo_q, bo_n;
  logic             ret_last;

  assign ret_last  = rd_valid && rd_last;
  assign out_cnt   = out_q;
  assign beats_out = bo_q;
  assign stale     = (disc_q != '0);
  assign live_idle = (out_q == disc_q);

  always_comb begin
    out_n  = out_q + CNT_W'(issue) - CNT_W'(ret_last);
    bo_n   = bo_q + (issue ? CW'(issue_beats) : '0) - CW'(rd_valid);
    disc_n = disc_q;
    if (restart)
      disc_n = out_q - CNT_W'(ret_last);
    else if (ret_last && stale)
      disc_n = disc_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= '0;
      bo_q   <= '0;
      disc_q <= '0;
    end else begin
      out_q  <= out_n;
      bo_q   <= bo_n;
      disc_q <= disc_n;
    end
  end

  AST_STALE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    disc_q <= out_q); // R10
endmodule

// File: rtl/fb_line_walker.sv
module fb_line_walker import fb_fetch_pkg::*; #(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               abort,
  input  logic               underrun,
  input  logic               accept,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_line_bytes,
  input  logic [LINES_W-1:0] cfg_lines,
  input  logic [ADDR_W-1:0]  cfg_pitch,
  input  logic [BURST_W-1:0] cfg_burst,
  output logic               want,
  output logic               busy,
  output logic [ADDR_W-1:0]  rq_addr,
  output logic [BURST_W-1:0] rq_beats
);
  localparam logic [BURST_W-1:0] BMAX = BURST_W'(MAX_BEATS);

  logic               fetch_q, fetch_n, stop_q, stop_n;
  logic [ADDR_W-1:0]  line_q, line_n, cur_q, cur_n;
  logic [LEN_W-1:0]   left_q, left_n, line_beats;
  logic [LINES_W-1:0] rows_q, rows_n;
  logic [BURST_W-1:0] burst_eff;
  logic               line_end;

  assign line_beats = cfg_line_bytes >> BEAT_SH;
  assign want       = fetch_q && !stop_q;
  assign busy       = fetch_q;
  assign rq_addr    = cur_q;

  always_comb begin
    if (cfg_burst == '0)     burst_eff = BURST_W'(1);
    else if (cfg_burst > BMAX) burst_eff = BMAX;
    else                     burst_eff = cfg_burst;
    rq_beats = (left_q < LEN_W'(burst_eff)) ? left_q[BURST_W-1:0] : burst_eff;
    line_end = (LEN_W'(rq_beats) == left_q);
  end

  always_comb begin
    fetch_n = fetch_q;
    stop_n  = stop_q;
    line_n  = line_q;
    cur_n   = cur_q;
    left_n  = left_q;
    rows_n  = rows_q;
    if (start) begin
      fetch_n = (cfg_lines != '0) && (line_beats != '0);
      stop_n  = 1'b0;
      line_n  = cfg_base;
      cur_n   = cfg_base;
      left_n  = line_beats;
      rows_n  = cfg_lines;
    end else if (abort) begin
      fetch_n = 1'b0;
      stop_n  = 1'b0;
    end else begin
      if (underrun) stop_n = 1'b1;
      if (accept) begin
        if (line_end) begin
          rows_n = rows_q - LINES_W'(1);
          line_n = line_q + cfg_pitch;
          cur_n  = line_q + cfg_pitch;
          left_n = line_beats;
          if (rows_q == LINES_W'(1)) fetch_n = 1'b0;
        end else begin
          cur_n  = cur_q + (ADDR_W'(rq_beats) << BEAT_SH);
          left_n = left_q - LEN_W'(rq_beats);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_q <= 1'b0;
      stop_q  <= 1'b0;
      line_q  <= '0;
      cur_q   <= '0;
      left_q  <= '0;
      rows_q  <= '0;
    end else begin
      fetch_q <= fetch_n;
      stop_q  <= stop_n;
      line_q  <= line_n;
      cur_q   <= cur_n;
      left_q  <= left_n;
      rows_q  <= rows_n;
    end
  end

  AST_UNDERRUN_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && !start) |=> !want); // R9
endmodule

// File: rtl/fb_line_fetch.sv
module fb_line_fetch import fb_fetch_pkg::*; #(
  parameter int FIFO_DEPTH = 64,
  parameter int LEN_W      = 16,
  localparam int CW        = $clog2(FIFO_DEPTH + 1),
  localparam int SW        = CW + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               abort,
  input  logic               underrun,
  input  logic [ADDR_W-1:0]  cfg_base,
  input  logic [LEN_W-1:0]   cfg_line_bytes,
  input  logic [LINES_W-1:0] cfg_lines,
  input  logic [ADDR_W-1:0]  cfg_pitch,
  input  logic [BURST_W-1:0] cfg_burst,
  input  logic [OUT_W-1:0]   cfg_max_out,
  output logic               rq_valid,
  input  logic               rq_ready,
  output logic [ADDR_W-1:0]  rq_addr,
  output logic [BURST_W-1:0] rq_beats,
  input  logic               rd_valid,
  input  logic [BEAT_W-1:0]  rd_data,
  input  logic               rd_last,
  input  logic               rd_err,
  input  logic               fifo_pop,
  output logic [BEAT_W-1:0]  fifo_data,
  output logic               fifo_empty,
  output logic               dma_end,
  output logic               bus_err
);
  logic             restart, want, busy, accept, push, fifo_full;
  logic             stale, live_idle, credit_ok, room_ok, end_cond;
  logic [CNT_W-1:0] out_cnt;
  logic [CW-1:0]    beats_out, level;
  logic [OUT_W-1:0] max_eff;
  logic [SW-1:0]    need;
  logic             pend_q, pend_n, end_n, err_n;

  assign restart   = frame_start || abort;
  assign max_eff   = (cfg_max_out == '0) ? OUT_W'(1) : cfg_max_out;
  assign credit_ok = (out_cnt < CNT_W'(max_eff));
  assign need      = SW'(level) + SW'(beats_out) + SW'(rq_beats);
  assign room_ok   = (need <= SW'(FIFO_DEPTH));
  assign rq_valid  = want && !restart && credit_ok && room_ok;
  assign accept    = rq_valid && rq_ready;
  assign push      = rd_valid && !stale && !restart;

  fb_line_walker #(.LEN_W(LEN_W)) u_walk (
    .clk, .rst_n, .start(frame_start), .abort, .underrun, .accept,
    .cfg_base, .cfg_line_bytes, .cfg_lines, .cfg_pitch, .cfg_burst,
    .want, .busy, .rq_addr, .rq_beats
  );

  fb_burst_tracker #(.DEPTH(FIFO_DEPTH)) u_track (
    .clk, .rst_n, .issue(accept), .issue_beats(rq_beats),
    .rd_valid, .rd_last, .restart,
    .out_cnt, .beats_out, .stale, .live_idle
  );

  fb_pixel_fifo #(.DEPTH(FIFO_DEPTH), .W(BEAT_W)) u_fifo (
    .clk, .rst_n, .flush(restart), .push, .din(rd_data), .pop(fifo_pop),
    .dout(fifo_data), .empty(fifo_empty), .full(fifo_full), .level
  );

  always_comb begin
    end_cond = pend_q && !busy && live_idle && !restart && !underrun;
    pend_n   = pend_q;
    if (frame_start)                      pend_n = 1'b1;
    else if (abort || underrun || end_cond) pend_n = 1'b0;
    end_n = end_cond;
    err_n = rd_valid && rd_err && !stale && !restart;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      dma_end <= 1'b0;
      bus_err <= 1'b0;
    end else begin
      pend_q  <= pend_n;
      dma_end <= end_n;
      bus_err <= err_n;
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rq_valid && !rq_ready && !frame_start && !abort && !underrun)
      |=> (rq_valid && $stable(rq_addr) && $stable(rq_beats))); // R11
  AST_END_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |=> !dma_end); // R7
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_end |-> !want); // R7
  AST_FLUSHED: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> fifo_empty); // R10
endmodule

// File: tb/test_fb_line_fetch.sv
module test_fb_line_fetch;
  localparam int DEPTH = 32;
  localparam int LEN_W = 16;
  localparam int NF    = 5;
  localparam int T_BASE  [NF] = '{32'h1000, 32'h8000, 32'h2000, 32'h3000, 32'h4000};
  localparam int T_BYTES [NF] = '{160, 40, 264, 24, 128};
  localparam int T_LINES [NF] = '{3, 4, 2, 3, 2};
  localparam int T_PITCH [NF] = '{256, -64, 512, -24, 128};
  localparam int T_BURST [NF] = '{8, 16, 20, 0, 16};
  localparam int T_MAXO  [NF] = '{4, 2, 15, 0, 8};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, frame_start, abort, underrun;
  logic [31:0] cfg_base, cfg_pitch;
  logic [LEN_W-1:0] cfg_line_bytes;
  logic [11:0] cfg_lines;
  logic [4:0]  cfg_burst;
  logic [3:0]  cfg_max_out;
  logic        rq_valid, rq_ready;
  logic [31:0] rq_addr;
  logic [4:0]  rq_beats;
  logic        rd_valid, rd_last, rd_err, fifo_pop, fifo_empty, dma_end, bus_err;
  logic [63:0] rd_data, fifo_data;

  fb_line_fetch #(.FIFO_DEPTH(DEPTH), .LEN_W(LEN_W)) i_fb_line_fetch (
    .clk, .rst_n, .frame_start, .abort, .underrun,
    .cfg_base, .cfg_line_bytes, .cfg_lines, .cfg_pitch, .cfg_burst, .cfg_max_out,
    .rq_valid, .rq_ready, .rq_addr, .rq_beats,
    .rd_valid, .rd_data, .rd_last, .rd_err,
    .fifo_pop, .fifo_data, .fifo_empty, .dma_end, .bus_err
  );

  int total_chk = 0;
  int bad_chk   = 0;
  function automatic void chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    total_chk++;
    if (!ok) begin
      bad_chk++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endfunction

  function automatic logic [63:0] dfun(logic [31:0] a);
    return {~a, a};
  endfunction

  logic [63:0] exp_q [256];
  int n_exp, pidx, n_req, n_end, n_err;
  bit pop_en, err_next, mon_on, hold_pend;
  logic [31:0] er_base, e_pitch, haddr, ea, ba;
  int er_beat, e_lbeats, e_burst, e_maxo, eb;
  logic [31:0] q_addr [64];
  int q_beats [64];
  int q_wr, q_rd, cur_beat, lat;

  always @(negedge clk) begin
    if (rst_n) begin
      if (dma_end) n_end++;
      if (bus_err) n_err++;
      if (hold_pend && !frame_start && !abort)
        chk(rq_valid && rq_addr == haddr, "R11 waiting request held", rq_addr, haddr);
      rq_ready = ($urandom % 4) != 0;
      hold_pend = mon_on && rq_valid && !rq_ready && !frame_start && !abort && !underrun;
      haddr = rq_addr;
      if (rq_valid && rq_ready) begin
        n_req++;
        if (mon_on) begin
          ea = er_base + 32'(er_beat * 8);
          eb = (e_lbeats - er_beat < e_burst) ? e_lbeats - er_beat : e_burst;
          chk(rq_addr == ea, "R2 request address", rq_addr, ea);
          chk(int'(rq_beats) == eb, "R3 burst beats", rq_beats, eb);
          chk((q_wr - q_rd) < e_maxo, "R4 bursts in flight", q_wr - q_rd, e_maxo);
          er_beat += eb;
          if (er_beat >= e_lbeats) begin
            er_beat = 0;
            er_base = er_base + e_pitch;
          end
        end
        q_addr[q_wr % 64]  = rq_addr;
        q_beats[q_wr % 64] = int'(rq_beats);
        q_wr++;
      end
      rd_valid = 1'b0;
      rd_last  = 1'b0;
      rd_err   = 1'b0;
      if (lat > 0) lat--;
      else if (q_wr != q_rd) begin
        ba       = q_addr[q_rd % 64] + 32'(cur_beat * 8);
        rd_valid = 1'b1;
        rd_data  = dfun(ba);
        rd_last  = (cur_beat == q_beats[q_rd % 64] - 1);
        if (err_next) begin
          rd_err   = 1'b1;
          err_next = 1'b0;
        end
        cur_beat++;
        if (rd_last) begin
          q_rd++;
          cur_beat = 0;
          lat = $urandom % 4;
        end
      end
      fifo_pop = 1'b0;
      if (pop_en && !fifo_empty && ($urandom % 3) != 0) begin
        chk(pidx < n_exp && fifo_data == exp_q[pidx % 256], "R6 fifo beat order",
            fifo_data, exp_q[pidx % 256]);
        pidx++;
        fifo_pop = 1'b1;
      end
    end
  end

  task automatic start_frame(int base, int bytes, int lines, int pitch, int burst, int maxo);
    pop_en = 1'b0;
    cfg_base = 32'(base); cfg_line_bytes = LEN_W'(bytes); cfg_lines = 12'(lines);
    cfg_pitch = 32'(pitch); cfg_burst = 5'(burst); cfg_max_out = 4'(maxo);
    @(posedge clk); #1;
    n_exp = 0;
    for (int l = 0; l < lines; l++)
      for (int b = 0; b < bytes / 8; b++) begin
        exp_q[n_exp % 256] = dfun(32'(base) + 32'(l * pitch) + 32'(b * 8));
        n_exp++;
      end
    er_base = 32'(base); er_beat = 0; e_lbeats = bytes / 8; e_pitch = 32'(pitch);
    e_burst = (burst == 0) ? 1 : ((burst > 16) ? 16 : burst);
    e_maxo  = (maxo == 0) ? 1 : maxo;
    pidx = 0; n_req = 0; n_end = 0; n_err = 0; mon_on = 1'b1;
    frame_start = 1'b1;
    @(posedge clk); #1;
    frame_start = 1'b0;
    pop_en = 1'b1;
  endtask

  task automatic wait_frame();
    for (int k = 0; k < 4000; k++) begin
      if (n_end > 0 && pidx == n_exp) break;
      @(posedge clk);
    end
    repeat (10) @(posedge clk);
    #1;
  endtask

  task automatic run_tab(int i, bit inj);
    start_frame(T_BASE[i], T_BYTES[i], T_LINES[i], T_PITCH[i], T_BURST[i], T_MAXO[i]);
    if (inj) err_next = 1'b1;
    wait_frame();
    chk(n_end == 1, "R7 one end pulse per frame", n_end, 1);
    chk(pidx == n_exp, "R6 all beats delivered", pidx, n_exp);
    chk(n_err == (inj ? 1 : 0), "R8 error pulses", n_err, inj ? 1 : 0);
  endtask

  bit done = 1'b0;
  int snap;

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; abort = 1'b0; underrun = 1'b0;
    cfg_base = '0; cfg_line_bytes = '0; cfg_lines = '0; cfg_pitch = '0;
    cfg_burst = 5'd8; cfg_max_out = 4'd4;
    rq_ready = 1'b0; rd_valid = 1'b0; rd_last = 1'b0; rd_err = 1'b0; rd_data = '0;
    fifo_pop = 1'b0; pop_en = 1'b0; err_next = 1'b0; mon_on = 1'b0; hold_pend = 1'b0;
    q_wr = 0; q_rd = 0; cur_beat = 0; lat = 0;
    n_exp = 0; pidx = 0; n_req = 0; n_end = 0; n_err = 0;
    repeat (3) @(posedge clk);
    #1;
    chk(!rq_valid && !dma_end && !bus_err, "R1 outputs idle in reset",
        {rq_valid, dma_end, bus_err}, 0);
    chk(fifo_empty, "R1 fifo empty in reset", fifo_empty, 1);
    rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    chk(!rq_valid && fifo_empty, "R1 idle before first start", {rq_valid, fifo_empty}, 1);

    for (int i = 0; i < NF; i++) run_tab(i, i == 0);

    // underrun: reader stalled, so the room rule caps requests at two bursts
    start_frame(T_BASE[2], T_BYTES[2], T_LINES[2], T_PITCH[2], T_BURST[2], T_MAXO[2]);
    pop_en = 1'b0;
    repeat (30) @(posedge clk);
    #1;
    underrun = 1'b1;
    @(posedge clk); #1;
    underrun = 1'b0;
    snap = n_req;
    chk(snap <= 2, "R5 room limits bursts while unread", snap, 2);
    pop_en = 1'b1;
    repeat (200) @(posedge clk);
    #1;
    chk(n_req == snap, "R9 no requests after underrun", n_req, snap);
    chk(n_end == 0, "R9 no end pulse after underrun", n_end, 0);
    run_tab(4, 1'b0); // R12 normal frame after underrun
    chk(n_req == 2, "R12 resumed request count", n_req, 2);

    // zero-line frame
    start_frame(32'h5000, 64, 0, 64, 8, 4);
    repeat (20) @(posedge clk);
    #1;
    chk(n_req == 0, "R7 zero lines issue nothing", n_req, 0);
    chk(n_end == 1, "R7 zero lines still end", n_end, 1);

    // abort with data in flight, then a new bottom-up frame
    start_frame(T_BASE[0], T_BYTES[0], T_LINES[0], T_PITCH[0], T_BURST[0], T_MAXO[0]);
    pop_en = 1'b0;
    repeat (6) @(posedge clk);
    #1;
    abort = 1'b1;
    @(posedge clk); #1;
    abort = 1'b0;
    chk(fifo_empty, "R10 abort empties fifo", fifo_empty, 1);
    run_tab(1, 1'b0); // R10 stale beats must not appear

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
      $finish;
    end
  end
endmodule